// File: doc/BRIEF.md
# Write-Through SECDED Data Cache with Hardware Error Recovery

This block is a small direct-mapped data cache between a processor load/store port and a slower lower-level memory with a request/ready handshake. Stores always go through to lower memory, so the cache never holds the only good copy of a word. Every cached word is kept as a 39-bit single-error-correcting, double-error-detecting codeword. A one-bit upset is repaired on the way out. A two-bit upset cannot be repaired, and the access is not aborted: the line is dropped and the word is fetched again from lower memory, which still holds the right value.

Recovery and reporting are kept apart. Each uncorrectable detection raises a one-cycle internal event. A software-set export bit decides whether that event reaches the event output pin. The event fires even when the recovery succeeds. Two saturating counters track correctable and uncorrectable detections, and a register holds the line index of the last detection. When recovery is switched off, a two-bit error is instead returned with an error flag. A fault-injection mask flips chosen bits of any codeword as it is written into the array, so the error paths can be exercised.

Top module: `ecc_wt_cache`

## Requirements
- R1: Every accepted store produces exactly one lower-memory write with the store's address and data. On a hit the cached word is updated. On a miss no line is allocated and the resident line is left unchanged.
- R2: A read miss issues one lower-memory read, fills the line and returns the fetched word with `cpu_rerr` low. A later read of the same address hits without any lower-memory traffic.
- R3: A read hit whose stored codeword has one flipped bit, at any of the 39 positions, returns the original word with `cpu_rerr` low and no lower-memory read.
- R4: A read hit with two flipped bits, with `cfg_recover_en` high, invalidates the line, performs exactly one lower-memory read and returns the fetched word with `cpu_rerr` low. The next read of that address hits cleanly.
- R5: Each uncorrectable detection drives `ev_uncorr` high for exactly one cycle if `cfg_export_en` was high when it was detected, and not at all otherwise.
- R6: With `cfg_recover_en` low, a two-bit error returns `cpu_rerr` high with no lower-memory read, and the line stays resident, so a repeat read reports the error again.
- R7: `cnt_corr` and `cnt_uncorr` each count one per correctable or uncorrectable read-hit detection, and they hold at all-ones instead of wrapping.
- R8: `last_err_idx` holds the line index (address bits [3:0]) of the most recent detection of either kind.
- R9: From the cycle a request is accepted until its read data is returned or its store has been handed to lower memory, `cpu_ready` stays low. A store issued right after a recovery refetch updates the refetched line and writes through.
- R10: After reset, `cpu_ready` is high, `cpu_rvalid`, `ev_uncorr` and `mem_req` are low, both counters are zero and all lines are invalid.
- R11: Bit k of `inj_mask` inverts bit k of the 39-bit codeword stored by any array write. Bit 0 is the overall parity, and bits 1 to 38 are Hamming positions 1 to 38, with check bits at positions 1, 2, 4, 8, 16 and 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_recover_en | input | 1 | Enables invalidate-and-refetch on uncorrectable errors |
| cfg_export_en | input | 1 | Lets the uncorrectable event reach `ev_uncorr` |
| inj_mask | input | 39 | Bits inverted in the codeword on every array write |
| cpu_req | input | 1 | Processor request; accepted when `cpu_ready` is high |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 8 | Word address: tag [7:4], line index [3:0] |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Port idle, a request can be taken |
| cpu_rvalid | output | 1 | One-cycle read data strobe |
| cpu_rdata | output | 32 | Read data |
| cpu_rerr | output | 1 | Read returned an unrecovered uncorrectable error |
| mem_req | output | 1 | Lower-memory request, held until `mem_ready` |
| mem_we | output | 1 | Lower-memory write when high |
| mem_addr | output | 8 | Lower-memory word address |
| mem_wdata | output | 32 | Lower-memory write data |
| mem_ready | input | 1 | Lower memory takes the request this cycle |
| mem_rvalid | input | 1 | Lower-memory read data strobe |
| mem_rdata | input | 32 | Lower-memory read data |
| ev_uncorr | output | 1 | Exported one-cycle uncorrectable-error event |
| cnt_corr | output | 8 | Saturating correctable-error count |
| cnt_uncorr | output | 8 | Saturating uncorrectable-error count |
| last_err_idx | output | 4 | Line index of the last detected error |

## Verification
The read path is swept with a single inverted bit at each of the 39 codeword positions, which separates a correct syndrome map from one that only repairs data bits or misplaces the parity bits. Twenty distinct bit pairs spanning the word tell real double detection apart from miscorrection, and counting lower-memory reads and event pulses separates recovery from reporting. Cold misses over every line, write hits and write misses show that stores write through without allocating. Reads with recovery off, and a store right after a refetch, cover the alternative error mode and the hold-off of a store behind recovery.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  // number of Hamming check bits for a given data width
  function automatic int hamming_bits(input int dw);
    for (int p = 1; p < 16; p++)
      if ((1 << p) >= dw + p + 1) return p;
    return 16;
  endfunction

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_FREQ, S_FWAIT, S_WREQ
  } wtc_state_e;
endpackage

// File: rtl/wtc_secded_enc.sv
module wtc_secded_enc #(
  parameter int DW = 32,
  localparam int HP = wtc_pkg::hamming_bits(DW),
  localparam int NPOS = DW + HP,
  localparam int CWW = NPOS + 1
) (
  input  logic [DW-1:0]  data,
  output logic [CWW-1:0] code
);
  always_comb begin
    int d;
    logic par;
    d = 0;
    code = '0;
    for (int i = 1; i <= NPOS; i++) begin
      if ((i & (i - 1)) != 0) begin
        code[i] = data[d];
        d++;
      end
    end
    for (int k = 0; k < HP; k++) begin
      par = 1'b0;
      for (int i = 1; i <= NPOS; i++)
        if (((i >> k) & 1) == 1) par ^= code[i];
      code[1 << k] = par;
    end
    code[0] = ^code[NPOS:1];
  end
endmodule

// File: rtl/wtc_secded_dec.sv
module wtc_secded_dec #(
  parameter int DW = 32,
  localparam int HP = wtc_pkg::hamming_bits(DW),
  localparam int NPOS = DW + HP,
  localparam int CWW = NPOS + 1
) (
  input  logic [CWW-1:0] code,
  output logic [DW-1:0]  data,
  output logic           err_single,
  output logic           err_double
);
  logic [CWW-1:0] fix;
  logic [HP-1:0]  syn;
  logic           ovr;

  always_comb begin
    int d;
    syn = '0;
    for (int i = 1; i <= NPOS; i++)
      if (code[i]) syn ^= HP'(i);
    ovr = ^code;
    fix = code;
    err_single = 1'b0;
    err_double = 1'b0;
    if (ovr) begin
      if (int'(syn) <= NPOS) begin
        fix[syn] = ~fix[syn];
        err_single = 1'b1;
      end else begin
        err_double = 1'b1;
      end
    end else if (syn != '0) begin
      err_double = 1'b1;
    end
    d = 0;
    data = '0;
    for (int i = 1; i <= NPOS; i++) begin
      if ((i & (i - 1)) != 0) begin
        data[d] = fix[i];
        d++;
      end
    end
  end
endmodule

// File: rtl/wtc_err_log.sv
module wtc_err_log #(
  parameter int IW    = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             det_en,
  input  logic             det_corr,
  input  logic             det_uncorr,
  input  logic [IW-1:0]    det_idx,
  input  logic             export_en,
  output logic             ev_out,
  output logic [CNT_W-1:0] cnt_corr,
  output logic [CNT_W-1:0] cnt_uncorr,
  output logic [IW-1:0]    last_idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ev_out     <= 1'b0;
      cnt_corr   <= '0;
      cnt_uncorr <= '0;
      last_idx   <= '0;
    end else begin
      ev_out <= det_en && det_uncorr && export_en;
      if (det_en && det_corr && cnt_corr != '1)
        cnt_corr <= cnt_corr + 1'b1;
      if (det_en && det_uncorr && cnt_uncorr != '1)
        cnt_uncorr <= cnt_uncorr + 1'b1;
      if (det_en && (det_corr || det_uncorr))
        last_idx <= det_idx;
    end
  end

  // R5: the exported event lasts one cycle only
  p_ev_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    ev_out |=> !ev_out);
  // R5: no event leaves unless export was enabled at detection
  p_ev_gate_r5: assert property (@(posedge clk) disable iff (rst)
    ev_out |-> $past(export_en));
  // R7: counters never go down (saturate, no wrap)
  p_cnt_sat_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt_corr >= $past(cnt_corr)) && (cnt_uncorr >= $past(cnt_uncorr)));
endmodule

// File: rtl/ecc_wt_cache.sv
module ecc_wt_cache #(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int LINES = 16,
  parameter int CNT_W = 8,
  localparam int IW   = $clog2(LINES),
  localparam int TW   = AW - IW,
  localparam int HP   = wtc_pkg::hamming_bits(DW),
  localparam int CWW  = DW + HP + 1,
  localparam int EW   = TW + CWW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_recover_en,
  input  logic             cfg_export_en,
  input  logic [CWW-1:0]   inj_mask,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [DW-1:0]    cpu_wdata,
  output logic             cpu_ready,
  output logic             cpu_rvalid,
  output logic [DW-1:0]    cpu_rdata,
  output logic             cpu_rerr,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_ready,
  input  logic             mem_rvalid,
  input  logic [DW-1:0]    mem_rdata,
  output logic             ev_uncorr,
  output logic [CNT_W-1:0] cnt_corr,
  output logic [CNT_W-1:0] cnt_uncorr,
  output logic [IW-1:0]    last_err_idx
);
  import wtc_pkg::*;

  wtc_state_e    st;
  logic [AW-1:0] a_q;
  logic [DW-1:0] wd_q;
  logic          we_q;
  logic [LINES-1:0] vld;
  logic [EW-1:0] arr [LINES];
  logic [EW-1:0] rd_q;
  logic          v_q;

  logic [IW-1:0] idx_q;
  logic [TW-1:0] tag_q;
  assign idx_q = a_q[IW-1:0];
  assign tag_q = a_q[AW-1:IW];

  // array write port: store hit or refill
  logic           aw_en;
  logic [DW-1:0]  aw_data;
  logic [CWW-1:0] enc_code;
  logic           hit;
  logic [DW-1:0]  dec_data;
  logic           dec_single, dec_double;

  assign hit     = v_q && (rd_q[EW-1:CWW] == tag_q);
  assign aw_en   = (st == S_LOOK && we_q && hit) || (st == S_FWAIT && mem_rvalid);
  assign aw_data = (st == S_FWAIT) ? mem_rdata : wd_q;

  wtc_secded_enc #(.DW(DW)) u_enc (.data(aw_data), .code(enc_code));
  wtc_secded_dec #(.DW(DW)) u_dec (
    .code(rd_q[CWW-1:0]), .data(dec_data),
    .err_single(dec_single), .err_double(dec_double));

  // block-RAM style storage: one write port, registered read
  always_ff @(posedge clk) begin
    if (aw_en) arr[idx_q] <= {tag_q, enc_code ^ inj_mask};
    if (st == S_IDLE && cpu_req) rd_q <= arr[cpu_addr[IW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      vld        <= '0;
      v_q        <= 1'b0;
      a_q        <= '0;
      wd_q       <= '0;
      we_q       <= 1'b0;
      cpu_rvalid <= 1'b0;
      cpu_rdata  <= '0;
      cpu_rerr   <= 1'b0;
    end else begin
      cpu_rvalid <= 1'b0;
      unique case (st)
        S_IDLE: if (cpu_req) begin
          a_q  <= cpu_addr;
          wd_q <= cpu_wdata;
          we_q <= cpu_we;
          v_q  <= vld[cpu_addr[IW-1:0]];
          st   <= S_LOOK;
        end
        S_LOOK: begin
          if (we_q) begin
            st <= S_WREQ;
          end else if (!hit) begin
            st <= S_FREQ;
          end else if (dec_double && cfg_recover_en) begin
            vld[idx_q] <= 1'b0;
            st <= S_FREQ;
          end else begin
            cpu_rvalid <= 1'b1;
            cpu_rdata  <= dec_data;
            cpu_rerr   <= dec_double;
            st <= S_IDLE;
          end
        end
        S_FREQ: if (mem_ready) st <= S_FWAIT;
        S_FWAIT: if (mem_rvalid) begin
          vld[idx_q] <= 1'b1;
          cpu_rvalid <= 1'b1;
          cpu_rdata  <= mem_rdata;
          cpu_rerr   <= 1'b0;
          st <= S_IDLE;
        end
        S_WREQ: if (mem_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cpu_ready = (st == S_IDLE);
  assign mem_req   = (st == S_FREQ) || (st == S_WREQ);
  assign mem_we    = (st == S_WREQ);
  assign mem_addr  = a_q;
  assign mem_wdata = wd_q;

  wtc_err_log #(.IW(IW), .CNT_W(CNT_W)) u_log (
    .clk(clk), .rst(rst),
    .det_en(st == S_LOOK && !we_q && hit),
    .det_corr(dec_single), .det_uncorr(dec_double), .det_idx(idx_q),
    .export_en(cfg_export_en), .ev_out(ev_uncorr),
    .cnt_corr(cnt_corr), .cnt_uncorr(cnt_uncorr), .last_idx(last_err_idx));

  // R1: an accepted store reaches lower memory two cycles later with its data
  p_store_wt_r1: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_ready && cpu_we) |-> ##2
      (mem_req && mem_we && mem_wdata == $past(cpu_wdata, 2)));
  // R2: read data strobe is a single cycle
  p_rvalid_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    cpu_rvalid |=> !cpu_rvalid);
  // R4: a lower-memory read, once taken, is not issued again for the same access
  p_one_fetch_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && mem_ready) |=> !mem_req);
  // R6: an error flag only comes with read data
  p_rerr_data_r6: assert property (@(posedge clk) disable iff (rst)
    cpu_rerr |-> cpu_rvalid || $stable(cpu_rerr));
  // R9: no request is taken while lower memory is busy for this access
  p_busy_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cpu_ready);
endmodule

// File: tb/ecc_wt_cache_bench.sv
module ecc_wt_cache_bench;
  localparam int CLK_P = 10;
  localparam int CW    = 4;
  localparam int SAT   = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_recover_en = 1'b1, cfg_export_en = 1'b1;
  logic [38:0] inj_mask = '0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [7:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic cpu_ready, cpu_rvalid, cpu_rerr;
  logic [31:0] cpu_rdata;
  logic mem_req, mem_we;
  logic [7:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic ev_uncorr;
  logic [CW-1:0] cnt_corr, cnt_uncorr;
  logic [3:0] last_err_idx;

  always #(CLK_P/2) clk = ~clk;

  ecc_wt_cache #(.CNT_W(CW)) u_ecc_wt_cache (
    .clk(clk), .rst(rst), .cfg_recover_en(cfg_recover_en), .cfg_export_en(cfg_export_en),
    .inj_mask(inj_mask), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid),
    .cpu_rdata(cpu_rdata), .cpu_rerr(cpu_rerr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .ev_uncorr(ev_uncorr),
    .cnt_corr(cnt_corr), .cnt_uncorr(cnt_uncorr), .last_err_idx(last_err_idx));

  int checks = 0, fails = 0;
  int rd_n = 0, wr_n = 0, ev_n = 0, cyc = 0, rdy_bad = 0;
  bit done = 0;
  logic [31:0] lmem [256];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int sat(input int n);
    return (n > SAT) ? SAT : n;
  endfunction

  // lower-memory model, driven away from the active edge
  initial begin
    int cd = 0;
    logic [7:0] pa = '0;
    for (int a = 0; a < 256; a++) lmem[a] = (a * 32'h0100_0193) ^ 32'hA5C3_0F1E;
    forever begin
      @(negedge clk);
      cyc++;
      if (ev_uncorr) ev_n++;
      mem_rvalid = 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin mem_rvalid = 1'b1; mem_rdata = lmem[pa]; end
      end
      mem_ready = (cyc % 3) != 1;
      if (mem_req && mem_ready) begin
        if (mem_we) begin lmem[mem_addr] = mem_wdata; wr_n++; end
        else begin rd_n++; pa = mem_addr; cd = 2; end
      end
    end
  end

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    @(negedge clk);
    cpu_req = 1'b0;
    while (!cpu_rvalid) begin
      if (cpu_ready) rdy_bad++;
      @(negedge clk);
    end
    d = cpu_rdata; e = cpu_rerr;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0;
    while (!cpu_ready) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic e;
    int f0, w0, e0, nbad;
    @(negedge clk);
    // R10 reset state
    check(cpu_ready && !cpu_rvalid && !ev_uncorr && !mem_req, "R10", "idle outputs",
          {cpu_ready, cpu_rvalid, ev_uncorr, mem_req}, 4'b1000);
    check(cnt_corr == 0 && cnt_uncorr == 0, "R10", "counters", {cnt_corr, cnt_uncorr}, 0);
    @(negedge clk);

    // R2 cold misses on all lines, then hits
    nbad = 0;
    for (int i = 0; i < 16; i++) begin
      f0 = rd_n; rd(8'(i), d, e);
      if (d !== lmem[i] || e !== 1'b0 || rd_n - f0 != 1) nbad++;
    end
    check(nbad == 0, "R2", "miss fill sweep", nbad, 0);
    nbad = 0;
    for (int i = 0; i < 16; i++) begin
      f0 = rd_n; rd(8'(i), d, e);
      if (d !== lmem[i] || rd_n - f0 != 0) nbad++;
    end
    check(nbad == 0, "R2", "hit sweep without fetch", nbad, 0);

    // R1 write hit and write miss
    w0 = wr_n; wr(8'h03, 32'hCAFE_0003);
    check(lmem[3] == 32'hCAFE_0003 && wr_n - w0 == 1, "R1", "hit write-through", lmem[3], 32'hCAFE_0003);
    f0 = rd_n; rd(8'h03, d, e);
    check(d == 32'hCAFE_0003 && rd_n == f0, "R1", "hit line updated", d, 32'hCAFE_0003);
    w0 = wr_n; wr(8'h53, 32'hBEEF_0053);
    check(lmem[8'h53] == 32'hBEEF_0053 && wr_n - w0 == 1, "R1", "miss write-through", lmem[8'h53], 32'hBEEF_0053);
    f0 = rd_n; rd(8'h03, d, e);
    check(d == 32'hCAFE_0003 && rd_n == f0, "R1", "no allocate on write miss", d, 32'hCAFE_0003);

    // R3/R11 single-bit sweep over all 39 codeword bits
    for (int k = 0; k < 39; k++) begin
      logic [7:0] a;
      a = 8'((2 + k / 16) * 16 + k % 16);
      inj_mask = 39'(1) << k;
      rd(a, d, e);
      inj_mask = '0;
      f0 = rd_n; rd(a, d, e);
      check(d == lmem[a] && !e && rd_n == f0, "R3", $sformatf("single flip bit %0d", k), d, lmem[a]);
      check(cnt_corr == CW'(sat(k + 1)), "R7", "correctable count", 32'(cnt_corr), 32'(sat(k + 1)));
    end
    check(last_err_idx == 4'd6 && cnt_uncorr == 0, "R8", "last index after singles", last_err_idx, 6);

    // R4/R5 double-bit sweep with recovery; export off for the first case
    for (int j = 0; j < 20; j++) begin
      logic [7:0] a;
      a = 8'((8 + j / 16) * 16 + j % 16);
      cfg_export_en = (j != 0);
      inj_mask = (39'(1) << j) | (39'(1) << (j + 19));
      rd(a, d, e);
      inj_mask = '0;
      f0 = rd_n; e0 = ev_n; nbad = rdy_bad;
      rd(a, d, e);
      repeat (2) @(negedge clk);
      check(d == lmem[a] && !e && rd_n - f0 == 1, "R4", $sformatf("recover pair %0d", j), d, lmem[a]);
      check(ev_n - e0 == ((j != 0) ? 1 : 0), "R5", "event export", ev_n - e0, (j != 0) ? 1 : 0);
      check(rdy_bad == nbad, "R9", "ready low during refetch", rdy_bad - nbad, 0);
      check(cnt_uncorr == CW'(sat(j + 1)), "R7", "uncorrectable count", 32'(cnt_uncorr), 32'(sat(j + 1)));
      f0 = rd_n; rd(a, d, e);
      check(d == lmem[a] && rd_n == f0, "R4", "clean hit after refetch", d, lmem[a]);
    end
    cfg_export_en = 1'b1;
    check(cnt_corr == CW'(SAT), "R7", "correctable held", 32'(cnt_corr), SAT);

    // R6 recovery disabled
    cfg_recover_en = 1'b0;
    inj_mask = (39'(1) << 2) | (39'(1) << 9);
    rd(8'hF5, d, e);
    inj_mask = '0;
    f0 = rd_n; rd(8'hF5, d, e);
    check(e && rd_n == f0, "R6", "error flag no fetch", {31'b0, e}, 1);
    rd(8'hF5, d, e);
    check(e && rd_n == f0, "R6", "line kept", {31'b0, e}, 1);
    check(last_err_idx == 4'd5, "R8", "last index", last_err_idx, 5);
    cfg_recover_en = 1'b1;
    rd(8'hF5, d, e);
    check(d == lmem[8'hF5] && !e && rd_n - f0 == 1, "R4", "recover after enable", d, lmem[8'hF5]);

    // R9 store right behind a recovery refetch
    inj_mask = (39'(1) << 30) | (39'(1) << 31);
    rd(8'hE2, d, e);
    inj_mask = '0;
    rd(8'hE2, d, e);
    w0 = wr_n; wr(8'hE2, 32'h1234_ABCD);
    f0 = rd_n; rd(8'hE2, d, e);
    check(d == 32'h1234_ABCD && rd_n == f0 && lmem[8'hE2] == 32'h1234_ABCD && wr_n - w0 == 1,
          "R9", "store after refetch", d, 32'h1234_ABCD);

    // R8 single error on line 9 moves the index
    inj_mask = 39'(1) << 17;
    rd(8'hA9, d, e);
    inj_mask = '0;
    rd(8'hA9, d, e);
    check(last_err_idx == 4'd9 && d == lmem[8'hA9], "R8", "index after single", last_err_idx, 9);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule